// File: doc/BRIEF.md
# Multiprocessor Interrupt Distributor

The block gathers a 32-bit bus of interrupt sources and turns it into one interrupt request per processor core, for a configurable number of cores. Lines 1 to 15 are ordinary lines, line 0 is never used, and lines 16 to 31 are extended lines. Each core sees a 4-bit request level naming the line it should service, with 0 meaning idle. Software sets the block up and services it through 32-bit registers on a zero-wait APB slave port.

Every ordinary line is delivered in one of two ways. In shared delivery, one pending bit is set and the first core to acknowledge the line clears it. In broadcast delivery, a private force bit is set in every core, and each core clears only its own. Extended lines reach the cores through a single ordinary line that software chooses as the cascade. When a core acknowledges that line, the number of the extended line being serviced is written into an identification register belonging to that core. All state updates on the clock edge, and requests follow combinationally, so nothing is pipelined.

Top module: `mpirq_ctrl`

## Requirements
- R1: After reset, all pending, force, mask, level, broadcast and identification registers read 0 and every request is 0. The status register at 0x10 reads the core count minus one in bits 31:28 and 0 elsewhere.
- R2: An ordinary line 1..15 that is high on a clock edge, and is not in broadcast delivery, sets its bit in the pending register (0x04, bits 15:1) at that edge. Extended line k sets bit k of the same register. Line 0 is ignored.
- R3: The request of core m (bits 4m+3:4m of `irq_req_o`) is updated in the cycle after the state changes. It is the highest-numbered active line among those whose level bit (0x00) is 1. If no such line is active, it is the highest-numbered active line overall. It is 0 when no line is active.
- R4: A 0 in bit n of core m's mask register (0x40+4m) stops line n from being requested for core m. Bits 31:16 of the mask gate the extended lines for that core.
- R5: When a line's bit is set in the broadcast register (0x14) and there is more than one core, an assertion of that line sets the line's bit in every core's force register (0x80+4m) and leaves the pending bit clear.
- R6: An acknowledge from any core clears the acknowledged line's pending bit. This includes a core whose mask excludes that line.
- R7: An acknowledge from core m clears bit n only in core m's own force register.
- R8: A write to 0x04 replaces the pending contents. A write to 0x0C clears the pending bits written as 1. A write to 0x08 ORs the data into every core's force register, and a read of 0x08 returns the OR of all force registers.
- R9: Bits 19:16 of 0x10 choose the cascade line, and 0 turns cascading off. When the cascade is on and core m has an unmasked pending extended line, the cascade line counts as active for core m.
- R10: An acknowledge of the cascade line by a core that has an eligible extended line does two things: it writes 16 plus the lowest eligible extended line number into that core's identification register (0xC0+4m, bits 4:0), and it clears only that extended pending bit.
- R11: Identification registers ignore writes.
- R12: With a single core, the broadcast register has no effect, and an assertion sets the pending bit.
- R13: An assertion in the same cycle as an acknowledge of the same line leaves the pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | 8 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| irq_i | input | 32 | Interrupt source lines |
| ack_valid_i | input | NCPU | Per-core acknowledge strobe |
| ack_line_i | input | 4*NCPU | Per-core acknowledged line number |
| irq_req_o | output | 4*NCPU | Per-core requested line, 0 = none |

## Verification
The bench builds the main instance with NCPU=2. At that size, every ordinary line, every pair of lines under all four level combinations, every broadcast line and every extended line through the cascade can each be swept in full. Two cores are enough to show that acknowledges, force bits and identification registers stay private to each core. A second instance with NCPU=1 shows that the broadcast register is ignored in a single-core setup.

// File: rtl/mpirq_pkg.sv
package mpirq_pkg;
  localparam int NLINES = 16;
  localparam int LW     = 4;
  localparam logic [5:0] OFS_LEVEL  = 6'h00;
  localparam logic [5:0] OFS_PEND   = 6'h04;
  localparam logic [5:0] OFS_GFORCE = 6'h08;
  localparam logic [5:0] OFS_CLEAR  = 6'h0C;
  localparam logic [5:0] OFS_STATUS = 6'h10;
  localparam logic [5:0] OFS_BCAST  = 6'h14;
  localparam logic [1:0] GRP_GLOBAL = 2'b00;
  localparam logic [1:0] GRP_MASK   = 2'b01;
  localparam logic [1:0] GRP_FORCE  = 2'b10;
  localparam logic [1:0] GRP_EID    = 2'b11;
  localparam logic [NLINES-1:0] LINE_VALID = 16'hFFFE;
endpackage

// File: rtl/mpirq_prio.sv
module mpirq_prio #(
  parameter int W = 16,
  parameter bit HIGH_FIRST = 1'b1,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  if (HIGH_FIRST) begin : g_hi
    always_comb begin
      idx_o = '0;
      for (int i = 0; i < W; i++) if (vec_i[i]) idx_o = IW'(i);
    end
  end else begin : g_lo
    always_comb begin
      idx_o = '0;
      for (int i = W - 1; i >= 0; i--) if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/mpirq_core.sv
module mpirq_core
  import mpirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_we_i,
  input  logic              force_we_i,
  input  logic              gforce_we_i,
  input  logic [31:0]       wdata_i,
  input  logic [NLINES-1:0] bcast_set_i,
  input  logic [NLINES-1:0] pending_i,
  input  logic [NLINES-1:0] ext_pend_i,
  input  logic [NLINES-1:0] level_i,
  input  logic [LW-1:0]     casc_i,
  input  logic              ack_valid_i,
  input  logic [LW-1:0]     ack_line_i,
  output logic [LW-1:0]     req_o,
  output logic [31:0]       mask_o,
  output logic [NLINES-1:0] force_o,
  output logic [4:0]        eid_o,
  output logic [NLINES-1:0] ext_take_o,
  output logic [NLINES-1:0] pend_clr_o
);
  logic [31:0]       mask_q;
  logic [NLINES-1:0] force_q, force_base;
  logic [4:0]        eid_q;
  logic [NLINES-1:0] ext_eff, casc_vec, active, hi, pick, ack_oh;
  logic              ext_any, take;
  logic [LW-1:0]     low_idx;

  assign ext_eff  = ext_pend_i & mask_q[31:16];
  assign ext_any  = (casc_i != '0) && (ext_eff != '0);
  assign casc_vec = ext_any ? (NLINES'(1) << casc_i) : '0;
  assign active   = (pending_i | force_q | casc_vec) & mask_q[15:0] & LINE_VALID;
  assign hi       = active & level_i;
  assign pick     = (hi != '0) ? hi : active;

  mpirq_prio #(.W(NLINES), .HIGH_FIRST(1'b1)) u_req (.vec_i(pick),    .idx_o(req_o));
  mpirq_prio #(.W(NLINES), .HIGH_FIRST(1'b0)) u_ext (.vec_i(ext_eff), .idx_o(low_idx));

  assign ack_oh     = ack_valid_i ? ((NLINES'(1) << ack_line_i) & LINE_VALID) : '0;
  assign take       = ack_valid_i && ext_any && (ack_line_i == casc_i);
  assign ext_take_o = take ? (NLINES'(1) << low_idx) : '0;
  assign pend_clr_o = ack_oh;

  always_comb begin
    force_base = force_q;
    if (force_we_i)       force_base = wdata_i[15:0];
    else if (gforce_we_i) force_base = force_q | wdata_i[15:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      force_q <= '0;
      eid_q   <= '0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i & 32'hFFFF_FFFE;
      force_q <= ((force_base & ~ack_oh) | bcast_set_i) & LINE_VALID;
      if (take) eid_q <= {1'b1, low_idx};
    end
  end

  assign mask_o  = mask_q;
  assign force_o = force_q;
  assign eid_o   = eid_q;
endmodule

// File: rtl/mpirq_ctrl.sv
module mpirq_ctrl
  import mpirq_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [7:0]        paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  input  logic [31:0]       irq_i,
  input  logic [NCPU-1:0]   ack_valid_i,
  input  logic [4*NCPU-1:0] ack_line_i,
  output logic [4*NCPU-1:0] irq_req_o
);
  logic [NLINES-1:0] level_q, pend_q, ext_q, bcast_q, bcast_eff;
  logic [LW-1:0]     casc_q;
  logic              apb_wr, aligned;
  logic [1:0]        grp;
  logic [3:0]        core_sel;
  logic [5:0]        ofs;
  logic              wr_level, wr_pend, wr_gforce, wr_clr, wr_status, wr_bcast;
  logic [NCPU-1:0][31:0]       mask_a;
  logic [NCPU-1:0][NLINES-1:0] force_a, ext_take_a, pend_clr_a;
  logic [NCPU-1:0][4:0]        eid_a;
  logic [NLINES-1:0] bcast_set, pend_clr_any, ext_take_any, force_or;
  logic [NLINES-1:0] pend_base, ext_base;

  assign apb_wr   = psel_i & penable_i & pwrite_i;
  assign aligned  = paddr_i[1:0] == 2'b00;
  assign grp      = paddr_i[7:6];
  assign core_sel = paddr_i[5:2];
  assign ofs      = paddr_i[5:0];

  assign wr_level  = apb_wr && aligned && grp == GRP_GLOBAL && ofs == OFS_LEVEL;
  assign wr_pend   = apb_wr && aligned && grp == GRP_GLOBAL && ofs == OFS_PEND;
  assign wr_gforce = apb_wr && aligned && grp == GRP_GLOBAL && ofs == OFS_GFORCE;
  assign wr_clr    = apb_wr && aligned && grp == GRP_GLOBAL && ofs == OFS_CLEAR;
  assign wr_status = apb_wr && aligned && grp == GRP_GLOBAL && ofs == OFS_STATUS;
  assign wr_bcast  = apb_wr && aligned && grp == GRP_GLOBAL && ofs == OFS_BCAST;

  if (NCPU > 1) begin : g_mp
    assign bcast_eff = bcast_q;
  end else begin : g_up
    assign bcast_eff = '0;
  end

  assign bcast_set = irq_i[15:0] & bcast_eff & LINE_VALID;

  for (genvar m = 0; m < NCPU; m++) begin : g_core
    logic mask_we, force_we;
    assign mask_we  = apb_wr && aligned && grp == GRP_MASK  && core_sel == 4'(m);
    assign force_we = apb_wr && aligned && grp == GRP_FORCE && core_sel == 4'(m);
    mpirq_core u_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mask_we_i   (mask_we),
      .force_we_i  (force_we),
      .gforce_we_i (wr_gforce),
      .wdata_i     (pwdata_i),
      .bcast_set_i (bcast_set),
      .pending_i   (pend_q),
      .ext_pend_i  (ext_q),
      .level_i     (level_q),
      .casc_i      (casc_q),
      .ack_valid_i (ack_valid_i[m]),
      .ack_line_i  (ack_line_i[4*m +: 4]),
      .req_o       (irq_req_o[4*m +: 4]),
      .mask_o      (mask_a[m]),
      .force_o     (force_a[m]),
      .eid_o       (eid_a[m]),
      .ext_take_o  (ext_take_a[m]),
      .pend_clr_o  (pend_clr_a[m])
    );
  end

  always_comb begin
    pend_clr_any = '0;
    ext_take_any = '0;
    force_or     = '0;
    for (int m = 0; m < NCPU; m++) begin
      pend_clr_any |= pend_clr_a[m];
      ext_take_any |= ext_take_a[m];
      force_or     |= force_a[m];
    end
  end

  always_comb begin
    pend_base = pend_q;
    ext_base  = ext_q;
    if (wr_pend) begin
      pend_base = pwdata_i[15:0];
      ext_base  = pwdata_i[31:16];
    end else if (wr_clr) begin
      pend_base = pend_q & ~pwdata_i[15:0];
      ext_base  = ext_q & ~pwdata_i[31:16];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      pend_q  <= '0;
      ext_q   <= '0;
      bcast_q <= '0;
      casc_q  <= '0;
    end else begin
      // new assertions win over clears in the same cycle
      pend_q <= ((pend_base & ~pend_clr_any) | (irq_i[15:0] & ~bcast_eff)) & LINE_VALID;
      ext_q  <= (ext_base & ~ext_take_any) | irq_i[31:16];
      if (wr_level)  level_q <= pwdata_i[15:0] & LINE_VALID;
      if (wr_bcast)  bcast_q <= pwdata_i[15:0] & LINE_VALID;
      if (wr_status) casc_q  <= pwdata_i[19:16];
    end
  end

  always_comb begin
    prdata_o = '0;
    if (psel_i && aligned) begin
      unique case (grp)
        GRP_GLOBAL: begin
          if (ofs == OFS_LEVEL)  prdata_o = {16'b0, level_q};
          if (ofs == OFS_PEND)   prdata_o = {ext_q, pend_q};
          if (ofs == OFS_GFORCE) prdata_o = {16'b0, force_or};
          if (ofs == OFS_STATUS) prdata_o = {4'(NCPU - 1), 8'b0, casc_q, 16'b0};
          if (ofs == OFS_BCAST)  prdata_o = {16'b0, bcast_q};
        end
        GRP_MASK:  for (int m = 0; m < NCPU; m++) if (core_sel == 4'(m)) prdata_o = mask_a[m];
        GRP_FORCE: for (int m = 0; m < NCPU; m++) if (core_sel == 4'(m)) prdata_o = {16'b0, force_a[m]};
        GRP_EID:   for (int m = 0; m < NCPU; m++) if (core_sel == 4'(m)) prdata_o = {27'b0, eid_a[m]};
        default: prdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mpirq_chk.sv
module mpirq_chk #(
  parameter int NCPU = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [31:0]            irq_i,
  input logic [NCPU-1:0]        ack_valid_i,
  input logic [4*NCPU-1:0]      ack_line_i,
  input logic [4*NCPU-1:0]      irq_req_o,
  input logic [15:0]            pend_q,
  input logic [15:0]            ext_q,
  input logic [15:0]            bcast_eff,
  input logic                   apb_wr,
  input logic [NCPU-1:0][31:0]  mask_a,
  input logic [NCPU-1:0][15:0]  force_a
);
  p_pend_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_i[15:1] & ~bcast_eff[15:1]) != 15'b0) |=>
      (($past(irq_i[15:1] & ~bcast_eff[15:1]) & ~pend_q[15:1]) == 15'b0));

  p_ext_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i[31:16] != 16'b0) |=> (($past(irq_i[31:16]) & ~ext_q) == 16'b0));

  p_pend_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!apb_wr && ack_valid_i == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  for (genvar m = 0; m < NCPU; m++) begin : g_c
    p_req_masked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_req_o[4*m +: 4] != 4'd0) |-> mask_a[m][irq_req_o[4*m +: 4]]);

    p_force_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((irq_i[15:1] & bcast_eff[15:1]) != 15'b0) |=>
        (($past(irq_i[15:1] & bcast_eff[15:1]) & ~force_a[m][15:1]) == 15'b0));

    p_ack_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_valid_i[m] && ack_line_i[4*m +: 4] != 4'd0 && !apb_wr
        && !irq_i[ack_line_i[4*m +: 4]])
      |=> !pend_q[$past(ack_line_i[4*m +: 4])]);
  end
endmodule

bind mpirq_ctrl mpirq_chk #(.NCPU(NCPU)) u_chk (.*);

// File: tb/mpirq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mpirq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel0 = 0, psel1 = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata0, prdata1;
  logic [31:0] irq0 = '0, irq1 = '0;
  logic [1:0]  ackv0 = '0;
  logic [7:0]  ackl0 = '0;
  logic        ackv1 = 1'b0;
  logic [3:0]  ackl1 = '0;
  logic [7:0]  req0;
  logic [3:0]  req1;
  int n_chk = 0, n_err = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  mpirq_ctrl #(.NCPU(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel0), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata0), .irq_i(irq0),
    .ack_valid_i(ackv0), .ack_line_i(ackl0), .irq_req_o(req0));

  mpirq_ctrl #(.NCPU(1)) dut1_i (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel1), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata1), .irq_i(irq1),
    .ack_valid_i(ackv1), .ack_line_i(ackl1), .irq_req_o(req1));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int d, input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    if (d == 0) psel0 = 1; else psel1 = 1;
    pwrite = 1; paddr = a; pwdata = v; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel0 = 0; psel1 = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rdr(input int d, input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    if (d == 0) psel0 = 1; else psel1 = 1;
    pwrite = 0; paddr = a;
    #1 v = (d == 0) ? prdata0 : prdata1;
    psel0 = 0; psel1 = 0;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk); irq0 = v;
    @(negedge clk); irq0 = '0;
  endtask

  task automatic ack(input int m, input logic [3:0] ln);
    @(negedge clk); ackv0[m] = 1'b1; ackl0[4*m +: 4] = ln;
    @(negedge clk); ackv0 = '0; ackl0 = '0;
  endtask

  function automatic logic [3:0] top_of(input logic [15:0] v);
    logic [3:0] r = 0;
    for (int i = 1; i < 16; i++) if (v[i]) r = 4'(i);
    return r;
  endfunction

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rdr(0, 8'h04, rd); chk(rd, 0, "R1 pending");
    rdr(0, 8'h00, rd); chk(rd, 0, "R1 level");
    rdr(0, 8'h10, rd); chk(rd, 32'h1000_0000, "R1 status");
    rdr(0, 8'h44, rd); chk(rd, 0, "R1 mask1");
    rdr(0, 8'hC0, rd); chk(rd, 0, "R1 eid0");
    chk({24'b0, req0}, 0, "R1 req");

    wr(0, 8'h40, 32'hFFFF_FFFF);
    wr(0, 8'h44, 32'hFFFF_FFFF);
    rdr(0, 8'h40, rd); chk(rd, 32'hFFFF_FFFE, "R4 mask bit0 reads 0");

    // R2 R3 R6 single-line sweep
    for (int l = 0; l < 16; l++) begin
      pulse(32'(1) << l);
      rdr(0, 8'h04, rd); chk(rd, (l == 0) ? 0 : (32'(1) << l), "R2 pending line");
      chk({28'b0, req0[3:0]}, l, "R3 req core0");
      chk({28'b0, req0[7:4]}, l, "R3 req core1");
      ack(1, 4'(l));
      rdr(0, 8'h04, rd); chk(rd, 0, "R6 ack clears pending");
    end

    // R3 pair and level sweep
    for (int a = 1; a < 16; a++)
      for (int b = a + 1; b < 16; b++)
        for (int lv = 0; lv < 4; lv++) begin
          logic [15:0] pv, lvv, hv;
          pv  = (16'(1) << a) | (16'(1) << b);
          lvv = (lv[0] ? (16'(1) << a) : 16'h0) | (lv[1] ? (16'(1) << b) : 16'h0);
          hv  = pv & lvv;
          wr(0, 8'h00, {16'b0, lvv});
          wr(0, 8'h04, {16'b0, pv});
          chk({28'b0, req0[3:0]}, top_of(hv != 0 ? hv : pv), "R3 level priority");
        end
    wr(0, 8'h00, 0);
    wr(0, 8'h04, 0);

    // R4 mask sweep
    wr(0, 8'h04, 32'h0000_FFFE);
    for (int l = 1; l < 16; l++) begin
      wr(0, 8'h40, (32'(1) << l) - 2);
      chk({28'b0, req0[3:0]}, l - 1, "R4 masked core0");
      chk({28'b0, req0[7:4]}, 15, "R4 unmasked core1");
    end
    wr(0, 8'h04, 0);

    // R6 masked core ack still clears
    wr(0, 8'h40, 32'hFFFF_FFDE);
    pulse(32'h20);
    chk({28'b0, req0[3:0]}, 0, "R4 line5 masked");
    chk({28'b0, req0[7:4]}, 5, "R3 line5 core1");
    ack(0, 4'd5);
    rdr(0, 8'h04, rd); chk(rd, 0, "R6 masked ack clears");
    wr(0, 8'h40, 32'hFFFF_FFFF);

    // R5 R7 broadcast sweep
    for (int l = 1; l < 16; l++) begin
      wr(0, 8'h14, 32'(1) << l);
      pulse(32'(1) << l);
      rdr(0, 8'h04, rd); chk(rd, 0, "R5 no pending");
      rdr(0, 8'h80, rd); chk(rd, 32'(1) << l, "R5 force0");
      rdr(0, 8'h84, rd); chk(rd, 32'(1) << l, "R5 force1");
      ack(0, 4'(l));
      rdr(0, 8'h80, rd); chk(rd, 0, "R7 own force cleared");
      rdr(0, 8'h84, rd); chk(rd, 32'(1) << l, "R7 other force kept");
      chk({28'b0, req0[3:0]}, 0, "R7 req0 idle");
      chk({28'b0, req0[7:4]}, l, "R7 req1 held");
      ack(1, 4'(l));
      rdr(0, 8'h84, rd); chk(rd, 0, "R7 force1 cleared");
    end
    wr(0, 8'h14, 0);

    // R8 register operations
    wr(0, 8'h04, 32'h0003_A5A5);
    rdr(0, 8'h04, rd); chk(rd, 32'h0003_A5A4, "R8 pending replace");
    wr(0, 8'h0C, 32'h0001_00F0);
    rdr(0, 8'h04, rd); chk(rd, 32'h0002_A504, "R8 clear");
    wr(0, 8'h04, 0);
    wr(0, 8'h08, 32'h24);
    rdr(0, 8'h80, rd); chk(rd, 32'h24, "R8 gforce core0");
    rdr(0, 8'h84, rd); chk(rd, 32'h24, "R8 gforce core1");
    wr(0, 8'h80, 0);
    wr(0, 8'h84, 32'h100);
    rdr(0, 8'h08, rd); chk(rd, 32'h100, "R8 gforce read OR");
    wr(0, 8'h84, 0);

    // R9 cascade off then on
    pulse(32'h0010_0000);
    chk({24'b0, req0}, 0, "R9 cascade off");
    rdr(0, 8'h04, rd); chk(rd, 32'h0010_0000, "R2 ext pending");
    wr(0, 8'h10, 32'h0009_0000);
    rdr(0, 8'h10, rd); chk(rd, 32'h1009_0000, "R9 status field");
    chk({28'b0, req0[3:0]}, 9, "R9 cascade req");
    ack(0, 4'd9);
    rdr(0, 8'hC0, rd); chk(rd, 20, "R10 eid 20");

    // R9 R10 extended sweep
    for (int e = 16; e < 32; e++) begin
      pulse(32'(1) << e);
      chk({28'b0, req0[3:0]}, 9, "R9 cascade core0");
      chk({28'b0, req0[7:4]}, 9, "R9 cascade core1");
      ack(0, 4'd9);
      rdr(0, 8'hC0, rd); chk(rd, e, "R10 eid value");
      rdr(0, 8'h04, rd); chk(rd, 0, "R10 ext cleared");
      chk({28'b0, req0[3:0]}, 0, "R10 req idle");
    end

    // R10 lowest first, others remain
    pulse(32'h0810_0000);
    ack(1, 4'd9);
    rdr(0, 8'hC4, rd); chk(rd, 20, "R10 lowest first");
    rdr(0, 8'h04, rd); chk(rd, 32'h0800_0000, "R10 other ext kept");
    chk({28'b0, req0[7:4]}, 9, "R10 still requested");
    rdr(0, 8'hC0, rd); chk(rd, 31, "R10 core0 eid untouched");
    ack(1, 4'd9);
    rdr(0, 8'hC4, rd); chk(rd, 27, "R10 second ext");

    // R4 extended mask, ack without eligible ext
    wr(0, 8'h44, 32'h0000_FFFE);
    pulse(32'h0004_0000);
    chk({28'b0, req0[7:4]}, 0, "R4 ext masked core1");
    chk({28'b0, req0[3:0]}, 9, "R9 ext core0");
    ack(1, 4'd9);
    rdr(0, 8'hC4, rd); chk(rd, 27, "R10 no capture when masked");
    rdr(0, 8'h04, rd); chk(rd, 32'h0004_0000, "R10 ext kept");
    ack(0, 4'd9);
    rdr(0, 8'hC0, rd); chk(rd, 18, "R10 eid 18");

    // R11 read-only id
    wr(0, 8'hC0, 32'h0000_001F);
    rdr(0, 8'hC0, rd); chk(rd, 18, "R11 eid write ignored");

    // R13 assert and ack same line in one cycle
    pulse(32'h80);
    @(negedge clk); irq0 = 32'h80; ackv0[0] = 1'b1; ackl0[3:0] = 4'd7;
    @(negedge clk); irq0 = '0; ackv0 = '0; ackl0 = '0;
    rdr(0, 8'h04, rd); chk(rd, 32'h80, "R13 set wins");
    ack(0, 4'd7);
    rdr(0, 8'h04, rd); chk(rd, 0, "R6 cleared after");

    // R12 single-core broadcast ignored
    wr(1, 8'h40, 32'hFFFF_FFFF);
    wr(1, 8'h14, 32'h10);
    @(negedge clk); irq1 = 32'h10;
    @(negedge clk); irq1 = '0;
    rdr(1, 8'h04, rd); chk(rd, 32'h10, "R12 pending set");
    rdr(1, 8'h80, rd); chk(rd, 0, "R12 no force");
    chk({28'b0, req1}, 4, "R12 req");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule